// File: doc/BRIEF.md
# JTAG TMS Sequencer

A register-driven JTAG master that walks a target's TAP controller by shifting a bit pattern supplied by software out on TMS while it generates TCK itself. One bus write starts a run of 1 to 32 TCK cycles. The run length comes from the low address bits of the write, and the TMS values come from the write data, taken from the least significant bit upward. A control register selects one of four TCK rates and holds four per-chip enables. It also holds a mask bit that parks the JTAG lines at known levels, so that board connectivity can be tested.

The block keeps its own 4-bit copy of the state the target's TAP controller should be in. This copy advances on every TCK rising edge that the block generates, so software can check where the target is without shifting any data. A status word returns the tracked state, the TDO input and the levels the block is driving on TCK, TMS and TDI. Bus reads are combinational on the address. Bus writes take effect at the clock edge that samples them.

Top module: `jtag_tms_seq`

## Requirements
- R1: After reset, TCK and TMS are 0, TDI is 1, all chip enables are 0, the busy flag reads 0, the control register reads 0 and the tracked state is 0 (Test-Logic-Reset).
- R2: A write to address 0xA0+i (address bits 7:5 = 101, i = bits 4:0) produces exactly i+1 TCK rising edges. Before the k-th rising edge, TMS carries write-data bit k, for k = 0..i. Data bits above i are never used.
- R3: With speed field s, TCK stays low for H = 2^(7-2s) clock cycles and then high for H cycles. The first rising edge comes H cycles after the clock edge that accepts the write, and the run ends 2(i+1)H cycles after that edge.
- R4: A read anywhere in 0xA0..0xBF returns the busy flag in bit 0. The flag is 1 from the accepting edge until the final TCK falling edge, and 0 after that.
- R5: A shift write that arrives while busy is ignored. It adds no TCK edges and does not change the TMS pattern or the tracked state.
- R6: Writing 0xC0 stores speed in bits 1:0, chip enables 1..4 in bits 5:2 and the mask in bit 6. Reading 0xC0 returns these 7 bits. The chip enable outputs follow bits 5:2 from the next cycle. Chip enable 1 also marks the TCK/TMS/TDI drivers as enabled.
- R7: While the mask bit is 1, TCK is 1 and TMS and TDI are 0. While it is 0, TDI idles at 1.
- R8: Reading 0xE0 returns TCK in bit 7, TMS in bit 6, TDI in bit 5, TDO in bit 4 and the tracked state in bits 3:0, all as driven at the pins.
- R9: The tracked state uses the encoding 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. It follows the IEEE 1149.1 transition graph and moves once on each generated TCK rising edge.
- R10: TMS changes only while TCK is low. It holds steady across every high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tdo | input | 1 | Test data from the target chain |
| tck | output | 1 | Generated test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target (idle level) |
| chip_en | output | 4 | Per-chip enables; bit 0 also enables the line drivers |

## Verification
The first TCK rising edge of a run is due H cycles after the accepting edge, and the k-th is due (2k+1)H cycles after it. The tracked state takes its new value at that same edge. Busy must still read 1 at cycle 2(i+1)H-1 and read 0 at cycle 2(i+1)H. The driver task counts cycles from the accepting edge, computes each rising-edge cycle from the speed in force, and queues the expected cycle, TMS level and next state. The monitor samples on the falling clock edge and, whenever it sees TCK go high, pops one entry and compares all three. Busy is probed exactly at the two boundary cycles. An edge that arrives with the queue empty, or an entry still left once the run is over, counts as a miscompare.

// File: rtl/jtag_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared TAP state encoding and the IEEE 1149.1 next-state function.
// Assumes a 4-bit state code, in the order software expects to read back.
package jtag_seq_pkg;

    typedef enum logic [3:0] {
        TAP_RESET  = 4'd0,
        TAP_IDLE   = 4'd1,
        TAP_SEL_DR = 4'd2,
        TAP_CAP_DR = 4'd3,
        TAP_SH_DR  = 4'd4,
        TAP_EX1_DR = 4'd5,
        TAP_PAU_DR = 4'd6,
        TAP_EX2_DR = 4'd7,
        TAP_UPD_DR = 4'd8,
        TAP_SEL_IR = 4'd9,
        TAP_CAP_IR = 4'd10,
        TAP_SH_IR  = 4'd11,
        TAP_EX1_IR = 4'd12,
        TAP_PAU_IR = 4'd13,
        TAP_EX2_IR = 4'd14,
        TAP_UPD_IR = 4'd15
    } tap_state_e;

    // Successor of a TAP state for a given TMS level at a TCK rising edge.
    function automatic tap_state_e tap_next(tap_state_e cur, logic sel);
        tap_state_e nxt;
        case (cur)
            TAP_RESET:  nxt = sel ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = sel ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = sel ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = sel ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  nxt = sel ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: nxt = sel ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = sel ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = sel ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: nxt = sel ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = sel ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = sel ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  nxt = sel ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: nxt = sel ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = sel ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = sel ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: nxt = sel ? TAP_SEL_DR : TAP_IDLE;
            default:    nxt = TAP_RESET;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/jtag_tck_gen.sv
`timescale 1ns/1ps
// TCK generator: while run is high, toggles tck every H system clocks, where
// H = 2^(2*(MAX_SPEED-speed)+1). Flags the clock cycle before each rising and
// falling edge. Assumes run stays high for whole TCK periods; when run is low
// the divider is held at zero with tck low.
module jtag_tck_gen #(
    parameter int SPEED_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SPEED_W-1:0] speed,
    output logic               tck,
    output logic               rise,
    output logic               fall
);
    localparam int MAX_SPEED = (1 << SPEED_W) - 1;
    localparam int TIMER_W   = 2 * MAX_SPEED + 1;

    logic [TIMER_W-1:0] timer;
    logic [TIMER_W-1:0] half_m1;
    logic               at_end;

    // Terminal count of one half period for the selected speed.
    always_comb begin
        int shift_amt;
        shift_amt = 2 * (MAX_SPEED - int'(speed)) + 1;
        half_m1   = TIMER_W'((64'd1 << shift_amt) - 64'd1);
    end

    assign at_end = (timer >= half_m1);
    assign rise   = run && at_end && !tck;
    assign fall   = run && at_end && tck;

    // Half-period divider and TCK toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            timer <= '0;
            tck   <= 1'b0;
        end else if (at_end) begin
            timer <= '0;
            tck   <= ~tck;
        end else begin
            timer <= timer + TIMER_W'(1);
        end
    end

    // R3: TCK stays low once the run has ended.
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tck);
    // R3: the shortest half period is two clocks, so a fresh high holds one more cycle.
    a_r3_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(tck)) |=> tck);

endmodule

// File: rtl/jtag_tms_shift.sv
`timescale 1ns/1ps
// TMS shifter: loads a pattern and a length when idle, presents the pattern
// LSB first on tms, and moves to the next bit on each TCK falling edge.
// busy drops on the falling edge that ends the last bit. Loads that arrive
// while busy are dropped.
module jtag_tms_shift #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              fall,
    output logic              busy,
    output logic              tms
);
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  rem;

    // Pattern, remaining-bit count and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '0;
            rem   <= '0;
        end else if (load && !busy) begin
            busy  <= 1'b1;
            shreg <= load_data;
            rem   <= load_len;
        end else if (busy && fall) begin
            if (rem == CNT_W'(1)) begin
                busy <= 1'b0;
            end else begin
                rem   <= rem - CNT_W'(1);
                shreg <= shreg >> 1;
            end
        end
    end

    assign tms = shreg[0];

    // R5: a load during a run leaves the pattern and count untouched.
    a_r5_busy_ignores_load: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && !fall) |=> (rem == $past(rem) && shreg == $past(shreg)));
    // R2: a run always has at least one bit left to send.
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem != '0));

endmodule

// File: rtl/jtag_tap_track.sv
`timescale 1ns/1ps
// TAP state tracker: keeps a copy of the expected target TAP state and steps
// it on each generated TCK rising edge using the TMS level at that edge.
// Assumes step is a one-cycle pulse that coincides with the rising edge.
module jtag_tap_track
    import jtag_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       tms,
    output tap_state_e state
);
    // State register, Test-Logic-Reset after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TAP_RESET;
        else if (step)
            state <= tap_next(state, tms);
    end

    // R9: the state only moves on a rising TCK edge.
    a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));
    // R9: TMS high in Select-IR returns to Test-Logic-Reset.
    a_r9_sel_ir_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (step && tms && state == TAP_SEL_IR) |=> state == TAP_RESET);

endmodule

// File: rtl/jtag_tms_seq.sv
`timescale 1ns/1ps
// JTAG TMS sequencer top: register decode, control register, pin drive and
// status readback around the TCK generator, TMS shifter and TAP tracker.
// Assumes a single-cycle write strobe and combinational reads.
module jtag_tms_seq
    import jtag_seq_pkg::*;
#(
    parameter int   ADDR_W   = 8,
    parameter int   DATA_W   = 32,
    parameter int   SPEED_W  = 2,
    parameter int   CHIPS    = 4,
    parameter logic TDI_IDLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic [CHIPS-1:0]  chip_en
);
    localparam int                IDX_W      = $clog2(DATA_W);
    localparam int                CNT_W      = IDX_W + 1;
    localparam int                CTRL_W     = SPEED_W + CHIPS + 1;
    localparam logic [ADDR_W-1:0] SHIFT_BASE = ADDR_W'(8'hA0);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(8'hC0);
    localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(8'hE0);
    localparam logic [ADDR_W-1:0] WIN_MASK   = ~ADDR_W'(DATA_W - 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic              mask;
    logic [SPEED_W-1:0] speed;
    logic              in_shift_win;
    logic              shift_wr;
    logic [CNT_W-1:0]  shift_len;
    logic              busy;
    logic              tck_int;
    logic              tms_int;
    logic              tck_rise;
    logic              tck_fall;
    tap_state_e        tap_state;

    assign speed   = ctrl_q[SPEED_W-1:0];
    assign chip_en = ctrl_q[SPEED_W +: CHIPS];
    assign mask    = ctrl_q[CTRL_W-1];

    assign in_shift_win = ((bus_addr & WIN_MASK) == SHIFT_BASE);
    assign shift_wr     = bus_we && in_shift_win;
    assign shift_len    = CNT_W'(bus_addr[IDX_W-1:0]) + CNT_W'(1);

    // Control register: speed, chip enables, mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_we && bus_addr == CTRL_ADDR)
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    jtag_tck_gen #(.SPEED_W(SPEED_W)) u_tck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .speed (speed),
        .tck   (tck_int),
        .rise  (tck_rise),
        .fall  (tck_fall)
    );

    jtag_tms_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shift_wr),
        .load_data (bus_wdata),
        .load_len  (shift_len),
        .fall      (tck_fall),
        .busy      (busy),
        .tms       (tms_int)
    );

    jtag_tap_track u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tck_rise),
        .tms   (tms_int),
        .state (tap_state)
    );

    // Pin levels, with the mask parking the lines.
    always_comb begin
        if (mask) begin
            tck = 1'b1;
            tms = 1'b0;
            tdi = 1'b0;
        end else begin
            tck = tck_int;
            tms = tms_int;
            tdi = TDI_IDLE;
        end
    end

    // Read mux over status, control and busy windows.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR)
            bus_rdata = DATA_W'({tck, tms, tdi, tdo, tap_state});
        else if (bus_addr == CTRL_ADDR)
            bus_rdata = DATA_W'(ctrl_q);
        else if (in_shift_win)
            bus_rdata = DATA_W'(busy);
    end

    // R10: TMS does not move during a TCK high phase.
    a_r10_tms_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_int && $past(tck_int)) |-> (tms_int == $past(tms_int)));
    // R4: a run ends together with a TCK falling edge.
    a_r4_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tck_int) && !tck_int));
    // R6: chip enables follow the control write.
    a_r6_chip_en_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTRL_ADDR) |=> (chip_en == $past(bus_wdata[SPEED_W +: CHIPS])));

endmodule

// File: tb/jtag_tms_seq_tb.sv
`timescale 1ns/1ps
module jtag_tms_seq_tb;

    typedef struct {
        int cyc;
        bit tms;
        int st;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'hE0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tdo = 1'b0;
    logic        tck, tms, tdi;
    logic [3:0]  chip_en;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   cur_speed = 0;
    int   mstate = 0;
    bit   mon_en = 1'b0;
    bit   prev_tck = 1'b0;
    bit   prev_tms = 1'b0;
    exp_t q[$];

    jtag_tms_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .chip_en(chip_en)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mnext(int s, bit t);
        case (s)
            0:  return t ? 0 : 1;
            1:  return t ? 2 : 1;
            2:  return t ? 9 : 3;
            3:  return t ? 5 : 4;
            4:  return t ? 5 : 4;
            5:  return t ? 8 : 6;
            6:  return t ? 7 : 6;
            7:  return t ? 8 : 4;
            8:  return t ? 2 : 1;
            9:  return t ? 0 : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    // Combinational probe away from the clock edges, then back to status.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
        bus_addr = 8'hE0;
    endtask

    // One bus write; returns with cyc equal to the accepting edge index.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #0.5;
        bus_we = 1'b0; bus_addr = 8'hE0;
    endtask

    // Driver: start a run of n bits, queue expected rises, check busy window.
    task automatic shift_run(int n, logic [31:0] pat, bit poke);
        int e0, h;
        logic [31:0] d;
        h = 1 << (7 - 2 * cur_speed);
        wr(8'hA0 + 8'(n - 1), pat);
        e0 = cyc;
        for (int k = 0; k < n; k++) begin
            exp_t it;
            mstate = mnext(mstate, pat[k]);
            it.cyc = e0 + (2 * k + 1) * h;
            it.tms = pat[k];
            it.st  = mstate;
            q.push_back(it);
        end
        if (poke) begin
            do @(negedge clk); while (cyc < e0 + h + 1);
            wr(8'hA0, 32'h0000_0001);   // R5: ignored while busy
        end
        do @(negedge clk); while (cyc < e0 + 2 * n * h - 1);
        #1;
        rd(8'hA0, d);
        chk("R4 busy before last fall", int'(d[0]), 1);
        @(negedge clk);
        #1;
        rd(8'hA0, d);
        chk("R4 busy after last fall", int'(d[0]), 0);
        chk("R2 queued rises left", q.size(), 0);
        rd(8'hE0, d);
        chk("R9 final tracked state", int'(d[3:0]), mstate);
        chk("R10 tck low at end", int'(tck), 0);
    endtask

    // Monitor: compare each TCK rise with the scoreboard queue.
    always @(negedge clk) begin
        if (mon_en) begin
            if (tck && !prev_tck) begin
                if (q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R5 unexpected rise: actual=cycle %0d expected=none", cyc);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk("R3 rise cycle", cyc, it.cyc);
                    chk("R2 tms at rise", int'(tms), int'(it.tms));
                    chk("R9 state after rise", int'(bus_rdata[3:0]), it.st);
                end
            end
            if (tck && prev_tck && tms != prev_tms)
                chk("R10 tms moved while tck high", int'(tms), int'(prev_tms));
        end
        prev_tck = tck;
        prev_tms = tms;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 tck", int'(tck), 0);
        chk("R1 tms", int'(tms), 0);
        chk("R1 tdi idle", int'(tdi), 1);
        chk("R1 chip_en", int'(chip_en), 0);
        rd(8'hA0, d); chk("R1 busy", int'(d), 0);
        rd(8'hC0, d); chk("R1 ctrl", int'(d), 0);
        rd(8'hE0, d); chk("R1 R8 status", int'(d), 32'h20);

        // R6 control register
        wr(8'hC0, 32'hFFFF_FF97);
        @(negedge clk); #1;
        rd(8'hC0, d); chk("R6 ctrl readback", int'(d), 32'h17);
        chk("R6 chip_en", int'(chip_en), 4'b0101);
        cur_speed = 3;
        mon_en = 1'b1;

        shift_run(5, 32'h0000_001F, 1'b0);   // stay in Test-Logic-Reset
        shift_run(4, 32'hFFFF_FFF2, 1'b0);   // to Shift-DR, upper bits unused
        wr(8'hC0, 32'h0000_0006);            // speed 2
        cur_speed = 2;
        shift_run(6, 32'h0000_000F, 1'b0);   // over to Shift-IR
        shift_run(3, 32'h0000_0003, 1'b1);   // with ignored write
        wr(8'hC0, 32'h0000_0004);            // speed 0
        cur_speed = 0;
        shift_run(2, 32'h0000_0001, 1'b0);
        wr(8'hC0, 32'h0000_0005);            // speed 1
        cur_speed = 1;
        shift_run(1, 32'hFFFF_FFFE, 1'b0);   // only bit 0 sent
        wr(8'hC0, 32'h0000_0007);            // speed 3
        cur_speed = 3;
        shift_run(32, 32'hA5C3_1E7F, 1'b0);  // full-width run

        // R7 mask and R8 readback
        mon_en = 1'b0;
        wr(8'hC0, 32'h0000_0047);
        @(negedge clk); #1;
        chk("R7 mask tck", int'(tck), 1);
        chk("R7 mask tms", int'(tms), 0);
        chk("R7 mask tdi", int'(tdi), 0);
        tdo = 1'b1;
        rd(8'hE0, d);
        chk("R8 masked status", int'(d), 32'h90 | mstate);
        wr(8'hC0, 32'h0000_0007);
        @(negedge clk); #1;
        chk("R7 unmasked tdi", int'(tdi), 1);
        rd(8'hE0, d);
        chk("R8 tdo bit", int'(d[4]), 1);
        chk("R8 tdi bit", int'(d[5]), 1);
        tdo = 1'b0;
        #1;
        rd(8'hE0, d);
        chk("R8 tdo low", int'(d[4]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule